// File: doc/BRIEF.md
# Nonvolatile Write Sequencer with Ready Status

This block sits behind the serial command decoder of a three-wire serial word memory. It owns the nonvolatile word array and the program-enable latch. It also times every programming operation. The decoder passes it each decoded instruction as a one-cycle request with an operation code, a word address and a data word. The block still watches the raw chip-select, serial clock and serial data lines. It uses chip-select edges to launch programming and to present status, and it uses the serial lines to detect a start bit.

A write-type request is held while chip-select is high and is launched by the falling edge of chip-select. It is launched only if the program-enable latch is set. Programming then runs for a fixed, parameterised number of clock cycles. The array is updated in one step at the end. If chip-select is raised during or after programming, the serial output drives a verify status: low means busy and high means ready. A start bit, or chip-select falling, releases the output to high impedance. A low-supply input clears the latch and cancels any held or running operation.

The controller is a three-state machine. SEQ_IDLE moves to SEQ_ARMED when a write-type request arrives. SEQ_ARMED moves to SEQ_PROG when chip-select falls with the latch set. SEQ_ARMED returns to SEQ_IDLE when chip-select falls with the latch clear, or when low supply is seen. SEQ_PROG returns to SEQ_IDLE when the timer expires or low supply aborts the operation. The output machine has three states. DO_HIZ moves to DO_BUSY or DO_READY when chip-select rises after a launch. DO_BUSY moves to DO_READY when programming ends. DO_BUSY and DO_READY both return to DO_HIZ when chip-select falls. DO_READY also returns to DO_HIZ on a start bit.

Top module: `nv_write_seq`

## Requirements
- R1: The req_op codes are 0 for enable, 1 for disable, 2 for WRITE, 3 for ERASE, 4 for write-all and 5 for erase-all. Code 0 sets the program-enable latch and code 1 clears it. Codes 2 to 5 start no programming and change no word while the latch is clear.
- R2: Reset and the low_supply input both clear the latch. A write-type request that is held when low_supply is seen is cancelled, and so is one that is running. No word changes, and a later write-type request without a new enable has no effect.
- R3: WRITE replaces all 16 bits of the addressed word with the request data, whatever the word held before. No prior erase is needed.
- R4: ERASE sets the addressed word to 16'hFFFF.
- R5: Write-all stores the request data in every word and ignores the request address.
- R6: Erase-all sets every word to 16'hFFFF.
- R7: Programming begins on the chip-select falling edge that follows a held write-type request. busy is high for exactly PROG_CYCLES cycles. The array keeps its old contents until busy falls.
- R8: While programming, chip-select raised makes do_oe high with do_o low from the next cycle. Chip-select low gives do_oe low.
- R9: After programming ends, chip-select raised gives do_o high. This repeats on every raise until a start bit is seen. If chip-select is held high across the end of programming, do_o goes from low to high within two cycles.
- R10: While the ready status is shown, a rising sk with di high returns do_oe to low on the next cycle.
- R11: While busy, sk and di are ignored and every request is dropped. req_dropped is high in the cycle after each dropped request.
- R12: Before any programming, every word reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_supply | input | 1 | Low-supply flag; clears the latch and cancels writes |
| cs | input | 1 | Chip select, sampled on clk |
| sk | input | 1 | Serial clock, sampled on clk |
| di | input | 1 | Serial data in, sampled on clk |
| req_valid | input | 1 | One-cycle decoded request strobe |
| req_op | input | 3 | Operation code (see R1) |
| req_addr | input | ADDR_W | Word address of the request |
| req_data | input | DATA_W | Data word of the request |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Word at rd_addr (combinational) |
| do_o | output | 1 | Serial output value |
| do_oe | output | 1 | Serial output drive enable (low = high impedance) |
| busy | output | 1 | Programming in progress |
| req_dropped | output | 1 | Pulses when a request arrives while busy |

## Verification
The bench builds the block with a 4-bit address (16 words) and PROG_CYCLES of 40. With 16 words, every word can be read back after each write-all and erase-all, which confirms both operations over the whole array. A 40-cycle programming window can be counted cycle by cycle. It also leaves room to poll status, toggle the serial clock and inject requests and low-supply pulses in the middle of an operation. Directed cases cover the latch, abort and status-release paths. A fixed-seed random run of mixed operations is compared against a word model kept in the bench.

// File: rtl/nvws_pkg.sv
package nvws_pkg;

    typedef enum logic [2:0] {
        OP_WEN   = 3'd0,
        OP_WDS   = 3'd1,
        OP_WRITE = 3'd2,
        OP_ERASE = 3'd3,
        OP_WRALL = 3'd4,
        OP_ERALL = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_PROG  = 2'd2
    } seq_e;

    typedef enum logic [1:0] {
        DO_HIZ   = 2'd0,
        DO_BUSY  = 2'd1,
        DO_READY = 2'd2
    } dout_e;

    function automatic logic is_prog_op(input logic [2:0] op);
        return (op == OP_WRITE) || (op == OP_ERASE) ||
               (op == OP_WRALL) || (op == OP_ERALL);
    endfunction

endpackage

// File: rtl/nvws_wel.sv
module nvws_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic low_supply,
    output logic wel_o
);
    logic wel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wel_q <= 1'b0;
        else if (low_supply || clr_req)
            wel_q <= 1'b0;
        else if (set_req)
            wel_q <= 1'b1;
    end

    assign wel_o = wel_q;

    // R2: low supply always leaves the latch clear
    p_lowsup_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        low_supply |=> !wel_q);

    // R1: enable without low supply or disable sets the latch
    p_enable_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && !clr_req && !low_supply) |=> wel_q);

endmodule

// File: rtl/nvws_timer.sv
module nvws_timer #(
    parameter int PROG_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(PROG_CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0)
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == '0) && !abort;

    // R7: busy can only rise through a start
    p_busy_needs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start) |=> !busy_q);

    // R7: completion ends the busy period
    p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start) |=> !busy_q);

endmodule

// File: rtl/nvws_array.sv
module nvws_array
    import nvws_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] BLANK = '1;

    logic [DATA_W-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++)
            mem[i] = BLANK;
    end

    always_ff @(posedge clk) begin
        if (commit) begin
            unique case (op_e'(op))
                OP_WRITE: mem[addr] <= data;
                OP_ERASE: mem[addr] <= BLANK;
                OP_WRALL: for (int i = 0; i < DEPTH; i++) mem[i] <= data;
                OP_ERALL: for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK;
                default:  ;
            endcase
        end
    end

    assign rd_data = mem[rd_addr];

    // R3: a committed WRITE lands its data at its address
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op == OP_WRITE) |=> mem[$past(addr)] == $past(data));

    // R4: a committed ERASE leaves the word blank
    p_erase_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op == OP_ERASE) |=> mem[$past(addr)] == BLANK);

    // R6: erase-all blanks the word being read
    p_erall_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op == OP_ERALL) |=> mem[rd_addr] == BLANK);

endmodule

// File: rtl/nvws_status.sv
module nvws_status
    import nvws_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic cs_rise,
    input  logic cs_fall,
    input  logic start_bit,
    input  logic busy,
    input  logic prog_start,
    output logic do_o,
    output logic do_oe
);
    dout_e st_q, st_d;
    logic  armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= DO_HIZ;
            armed_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (prog_start)
                armed_q <= 1'b1;
            else if (st_q == DO_READY && start_bit)
                armed_q <= 1'b0;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DO_HIZ: begin
                if (cs_rise && armed_q)
                    st_d = busy ? DO_BUSY : DO_READY;
            end
            DO_BUSY: begin
                if (cs_fall)
                    st_d = DO_HIZ;
                else if (!busy)
                    st_d = DO_READY;
            end
            DO_READY: begin
                if (cs_fall || start_bit)
                    st_d = DO_HIZ;
            end
            default: st_d = DO_HIZ;
        endcase
    end

    always_comb begin
        do_oe = (st_q != DO_HIZ);
        do_o  = (st_q == DO_READY);
    end

    // R8: chip-select low releases the output
    p_cs_low_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !do_oe);

    // R8: while programming, a driven output shows low
    p_busy_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && do_oe) |-> !do_o);

    // R10: start bit during ready releases the output
    p_start_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (do_oe && do_o && start_bit) |=> !do_oe);

endmodule

// File: rtl/nv_write_seq.sv
module nv_write_seq
    import nvws_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_supply,
    input  logic              cs,
    input  logic              sk,
    input  logic              di,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              do_o,
    output logic              do_oe,
    output logic              busy,
    output logic              req_dropped
);
    seq_e              state_q, state_d;
    logic              cs_q, sk_q;
    logic              cs_rise, cs_fall, sk_rise, start_bit;
    logic              req_prog, wel;
    logic              prog_start, prog_abort, prog_done, tmr_busy;
    logic              drop_q;
    logic [2:0]        pend_op_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [DATA_W-1:0] pend_data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= 1'b0;
            sk_q <= 1'b0;
        end else begin
            cs_q <= cs;
            sk_q <= sk;
        end
    end

    assign cs_rise   = cs && !cs_q;
    assign cs_fall   = !cs && cs_q;
    assign sk_rise   = sk && !sk_q;
    assign start_bit = cs && sk_rise && di && !tmr_busy;
    assign req_prog  = req_valid && is_prog_op(req_op);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SEQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (req_prog && !low_supply)
                    state_d = SEQ_ARMED;
            end
            SEQ_ARMED: begin
                if (low_supply)
                    state_d = SEQ_IDLE;
                else if (cs_fall)
                    state_d = wel ? SEQ_PROG : SEQ_IDLE;
            end
            SEQ_PROG: begin
                if (low_supply || prog_done)
                    state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_op_q   <= '0;
            pend_addr_q <= '0;
            pend_data_q <= '0;
            drop_q      <= 1'b0;
        end else begin
            drop_q <= req_valid && (state_q == SEQ_PROG);
            if (req_prog && !low_supply && state_q != SEQ_PROG) begin
                pend_op_q   <= req_op;
                pend_addr_q <= req_addr;
                pend_data_q <= req_data;
            end
        end
    end

    always_comb begin
        prog_start  = (state_q == SEQ_ARMED) && !low_supply && cs_fall && wel;
        prog_abort  = (state_q == SEQ_PROG) && low_supply;
        busy        = tmr_busy;
        req_dropped = drop_q;
    end

    nvws_wel u_wel (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_req    (req_valid && req_op == OP_WEN && state_q != SEQ_PROG),
        .clr_req    (req_valid && req_op == OP_WDS && state_q != SEQ_PROG),
        .low_supply (low_supply),
        .wel_o      (wel)
    );

    nvws_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (prog_start),
        .abort  (prog_abort),
        .busy_o (tmr_busy),
        .done_o (prog_done)
    );

    nvws_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (prog_done && state_q == SEQ_PROG),
        .op      (pend_op_q),
        .addr    (pend_addr_q),
        .data    (pend_data_q),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    nvws_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (cs),
        .cs_rise    (cs_rise),
        .cs_fall    (cs_fall),
        .start_bit  (start_bit),
        .busy       (tmr_busy),
        .prog_start (prog_start),
        .do_o       (do_o),
        .do_oe      (do_oe)
    );

    // R7: the sequencer state and the timer agree on programming
    p_prog_tracks_timer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_PROG) == tmr_busy);

    // R1: a launch without the latch never starts programming
    p_no_launch_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_ARMED && cs_fall && !wel) |=> !tmr_busy);

    // R2: low supply during programming aborts it
    p_lowsup_aborts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_PROG && low_supply) |=> (state_q == SEQ_IDLE && !tmr_busy));

    // R11: a request during programming raises the drop flag
    p_drop_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && state_q == SEQ_PROG) |=> req_dropped);

endmodule

// File: tb/nv_write_seq_tb.sv
module nv_write_seq_tb;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int PC = 40;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          low_supply = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0, rd_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [DW-1:0] rd_data;
    logic          do_o, do_oe, busy, req_dropped;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] model [NW];
    logic          m_wel;

    always #10 clk = ~clk;

    nv_write_seq #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .low_supply(low_supply), .cs(cs), .sk(sk),
        .di(di), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .rd_addr(rd_addr), .rd_data(rd_data), .do_o(do_o),
        .do_oe(do_oe), .busy(busy), .req_dropped(req_dropped));

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [DW-1:0] v);
        rd_addr = AW'(a);
        #1 v = rd_data;
    endtask

    task automatic chk_all(input string req);
        logic [DW-1:0] v;
        for (int i = 0; i < NW; i++) begin
            rd(i, v);
            chk(v == model[i], req, int'(v), int'(model[i]));
        end
    endtask

    function automatic logic is_prog(input logic [2:0] op);
        return op >= 3'd2 && op <= 3'd5;
    endfunction

    // model update for a completed, enabled operation
    task automatic apply(input logic [2:0] op, input int a, input logic [DW-1:0] d);
        case (op)
            3'd0: m_wel = 1'b1;
            3'd1: m_wel = 1'b0;
            3'd2: if (m_wel) model[a] = d;
            3'd3: if (m_wel) model[a] = '1;
            3'd4: if (m_wel) for (int i = 0; i < NW; i++) model[i] = d;
            3'd5: if (m_wel) for (int i = 0; i < NW; i++) model[i] = '1;
            default: ;
        endcase
    endtask

    // returns at the negedge after the launching chip-select fall
    task automatic issue(input logic [2:0] op, input int a, input logic [DW-1:0] d);
        @(negedge clk) cs = 1'b1;
        @(negedge clk) begin
            req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_data = d;
        end
        @(negedge clk) begin req_valid = 1'b0; cs = 1'b0; end
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        int cnt;
        void'($urandom(32'd1234));
        m_wel = 1'b0;
        for (int i = 0; i < NW; i++) model[i] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R2, R8)
        chk(busy == 1'b0, "R2 reset busy", busy, 0);
        chk(do_oe == 1'b0, "R8 reset hiz", do_oe, 0);
        chk(req_dropped == 1'b0, "R11 reset drop", req_dropped, 0);
        chk_all("R12 blank");

        // locked write (R1)
        issue(3'd2, 3, 16'h1111);
        chk(busy == 1'b0, "R1 locked no busy", busy, 0);
        chk_all("R1 locked unchanged");

        // enabled write with exact length (R7, R3)
        issue(3'd0, 0, 0); apply(3'd0, 0, 0);
        issue(3'd2, 3, 16'hA5A5);
        cnt = 0;
        while (busy) begin
            cnt++;
            if (cnt == PC / 2) begin
                rd(3, v);
                chk(v == 16'hFFFF, "R7 old until done", int'(v), 16'hFFFF);
            end
            @(negedge clk);
        end
        chk(cnt == PC, "R7 busy length", cnt, PC);
        apply(3'd2, 3, 16'hA5A5);
        chk_all("R3 write");
        issue(3'd2, 3, 16'h1234); wait_idle(); apply(3'd2, 3, 16'h1234);
        chk_all("R3 overwrite no erase");

        // verify polling (R8, R9, R10, R11)
        issue(3'd2, 7, 16'h00F0); apply(3'd2, 7, 16'h00F0);
        cs = 1'b1;
        @(negedge clk);
        chk(do_oe && !do_o, "R8 busy low", {do_oe, do_o}, 2);
        sk = 1'b1; di = 1'b1;
        @(negedge clk);
        chk(do_oe && !do_o, "R11 sk ignored busy", {do_oe, do_o}, 2);
        sk = 1'b0; di = 1'b0;
        req_valid = 1'b1; req_op = 3'd5;
        @(negedge clk) req_valid = 1'b0;
        chk(req_dropped == 1'b1, "R11 drop pulse", req_dropped, 1);
        cs = 1'b0;
        @(negedge clk);
        chk(do_oe == 1'b0, "R8 cs low hiz", do_oe, 0);
        wait_idle();
        @(negedge clk) cs = 1'b1;
        @(negedge clk);
        chk(do_oe && do_o, "R9 ready high", {do_oe, do_o}, 3);
        cs = 1'b0;
        @(negedge clk) cs = 1'b1;
        @(negedge clk);
        chk(do_oe && do_o, "R9 repeat poll", {do_oe, do_o}, 3);
        sk = 1'b1; di = 1'b1;
        @(negedge clk);
        chk(do_oe == 1'b0, "R10 start releases", do_oe, 0);
        sk = 1'b0; di = 1'b0; cs = 1'b0;
        @(negedge clk);
        chk_all("R11 dropped erase-all");

        // chip-select held across completion (R9)
        issue(3'd3, 7, 0); apply(3'd3, 7, 0);
        cs = 1'b1;
        wait_idle();
        @(negedge clk);
        chk(do_oe && do_o, "R9 held cs rises", {do_oe, do_o}, 3);
        cs = 1'b0;
        @(negedge clk);
        chk_all("R4 erase");

        // whole-array ops (R5, R6)
        issue(3'd4, 9, 16'h5AC3); wait_idle(); apply(3'd4, 9, 16'h5AC3);
        chk_all("R5 write-all");
        issue(3'd5, 2, 0); wait_idle(); apply(3'd5, 2, 0);
        chk_all("R6 erase-all");

        // low supply abort (R2)
        issue(3'd2, 2, 16'h0F0F);
        repeat (10) @(negedge clk);
        low_supply = 1'b1;
        @(negedge clk) low_supply = 1'b0;
        chk(busy == 1'b0, "R2 abort busy", busy, 0);
        m_wel = 1'b0;
        repeat (PC) @(negedge clk);
        chk_all("R2 abort unchanged");
        issue(3'd2, 2, 16'h0F0F);
        chk(busy == 1'b0, "R2 latch cleared", busy, 0);
        // low supply while held
        issue(3'd0, 0, 0); apply(3'd0, 0, 0);
        @(negedge clk) cs = 1'b1;
        @(negedge clk) begin req_valid = 1'b1; req_op = 3'd3; req_addr = 4'd1; end
        @(negedge clk) begin req_valid = 1'b0; low_supply = 1'b1; end
        @(negedge clk) begin low_supply = 1'b0; cs = 1'b0; end
        @(negedge clk);
        chk(busy == 1'b0, "R2 held cancelled", busy, 0);
        m_wel = 1'b0;
        chk_all("R2 held unchanged");

        // random mix
        for (int i = 0; i < 24; i++) begin
            logic [2:0] op;
            int a;
            logic [DW-1:0] d;
            op = 3'($urandom % 6);
            a = int'($urandom % NW);
            d = DW'($urandom);
            if (i % 4 == 0) begin issue(3'd0, 0, 0); apply(3'd0, 0, 0); end
            issue(op, a, d);
            if (is_prog(op))
                chk(busy == m_wel, "R1 random launch", busy, m_wel);
            wait_idle();
            apply(op, a, d);
        end
        chk_all("R3 random array");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule